// File: doc/BRIEF.md
# Two-Tone FSK Proximity Tag Emulator

This block makes a reader see a 44-bit proximity tag. It drives one coil-control bit, where 1 opens the coil and 0 shorts it. The bit advances by one sample on each rising edge of the reader's field clock. The field clock is brought into the system clock domain through a short synchronizer chain, and its rising edges are detected there. The samples are generated on the fly from two tones. An eight-sample tone stays high for two samples. A ten-sample tone stays high for three samples. No pattern memory is used.

Each frame is built as follows:
- It opens with one lone eight-sample cycle.
- A start marker follows. It is made of tone groups that do not form valid Manchester symbols.
- The ID comes next, most significant bit first. Each bit is a pair of tone groups.
- One lone eight-sample cycle is placed before every nibble.

The frame repeats with no gap until a stop request arrives. The ID arrives as a 32-bit upper word and a 32-bit lower word. Only the low 12 bits of the upper word belong to the ID. An upper word above 0xFFF blocks the start.

Top module: `fsk_tag_emu`

## Requirements
- R1: After reset the coil output is 0 (shorted) and the block is idle.
- R2: The coil output changes only one synchronized field-clock rising edge at a time. With no field edge and no stop request it holds its value.
- R3: An eight-sample tone cycle is 1,1,0,0,0,0,0,0. A ten-sample tone cycle is 1,1,1,0,0,0,0,0,0,0. A short-tone group is 6 cycles (48 samples). A long-tone group is 5 cycles (50 samples).
- R4: An ID bit of 1 is a long-tone group followed by a short-tone group. An ID bit of 0 is a short-tone group followed by a long-tone group.
- R5: A frame starts with one lone eight-sample cycle. The marker groups follow in the order short, short, short, long, long, long, short, long, which is 400 samples in total.
- R6: The ID is {upper[11:0], lower[31:0]}. It is sent from ID bit 43 down to ID bit 0.
- R7: One lone eight-sample cycle precedes ID bits 43, 39, 35, … 3. Each nibble therefore takes 400 samples.
- R8: A frame is 4800 samples. The next frame starts at its lone leading cycle on the very next field edge.
- R9: The ID inputs are captured only at start and when a frame wraps. Changes in mid-frame appear from the following frame onwards.
- R10: A stop request shorts the coil on the next system clock. The block then stays idle, with the coil at 0, whatever the field does.
- R11: A start request with any of upper[31:12] set is refused. The block stays idle with the coil at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fieldClk | input | 1 | Reader field clock (asynchronous, synchronized inside) |
| startReq | input | 1 | Begin emulation when idle |
| stopReq | input | 1 | End emulation at once (priority over start) |
| idHi | input | 32 | Upper ID word; bits 11:0 used, bits 31:12 must be 0 |
| idLo | input | 32 | Lower 32 ID bits |
| coilOpen | output | 1 | 1 opens the coil, 0 shorts it |

## Verification
A wrong sample or cycle count inside the tone generator shows at once as a misplaced high sample. The bench catches it within the first ten field edges, because it compares every sample with a model of the frame computed independently. A wrong sequencer state, such as a bad marker order, a missing nibble cycle, a wrong bit order or a wrong wrap point, shifts every later sample in the frame. It is reported at the first boundary it affects. A wrong ID capture shows only in the frame after an input change, so the bench changes the ID in mid-frame and checks both frames.

// File: rtl/fsk_emu_pkg.sv
package fsk_emu_pkg;

  typedef enum logic [1:0] {
    PH_LEAD,
    PH_MARK,
    PH_NIB,
    PH_BIT
  } phase_e;

  typedef struct packed {
    logic step;     // advance one sample
    logic clear;    // zero counters and short the coil
    logic toneTen;  // 1: long tone, 0: short tone
    logic single;   // element is one lone cycle, not a group
  } tone_ctl_t;

endpackage

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
  import fsk_emu_pkg::*;
#(
  parameter int SHORT_LEN  = 8,
  parameter int SHORT_HIGH = 2,
  parameter int SHORT_REPS = 6,
  parameter int LONG_LEN   = 10,
  parameter int LONG_HIGH  = 3,
  parameter int LONG_REPS  = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  tone_ctl_t ctl,
  output logic      coilOpen,
  output logic      elemLast
);
  localparam int SW = $clog2(LONG_LEN);
  localparam int MAX_REPS = (SHORT_REPS > LONG_REPS) ? SHORT_REPS : LONG_REPS;
  localparam int CW = $clog2(MAX_REPS);

  logic [SW-1:0] sampleIdx, lenM1, highLim;
  logic [CW-1:0] cycleIdx, repsM1;
  logic sampleLast, cycleLast;

  always_comb begin
    lenM1   = ctl.toneTen ? SW'(LONG_LEN - 1) : SW'(SHORT_LEN - 1);
    highLim = ctl.toneTen ? SW'(LONG_HIGH)    : SW'(SHORT_HIGH);
    if (ctl.single) repsM1 = '0;
    else            repsM1 = ctl.toneTen ? CW'(LONG_REPS - 1) : CW'(SHORT_REPS - 1);
  end

  assign sampleLast = (sampleIdx == lenM1);
  assign cycleLast  = (cycleIdx == repsM1);
  assign elemLast   = sampleLast && cycleLast;

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.clear) begin
      sampleIdx <= '0;
      cycleIdx  <= '0;
      coilOpen  <= 1'b0;
    end else if (ctl.step) begin
      coilOpen <= (sampleIdx < highLim);
      if (sampleLast) begin
        sampleIdx <= '0;
        cycleIdx  <= cycleLast ? '0 : cycleIdx + 1'b1;
      end else begin
        sampleIdx <= sampleIdx + 1'b1;
      end
    end
  end

  // R3: sample position never leaves the current tone cycle
  p_cycle_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sampleIdx <= lenM1);

  // R3: lone cycles never count past their first repetition
  p_single_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.single |-> cycleIdx == '0);

endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
  import fsk_emu_pkg::*;
#(
  parameter int ID_W  = 44,
  parameter int HI_W  = 32,
  parameter int LO_W  = 32,
  parameter int NIB_W = 4,
  parameter int MARK_N = 8,
  parameter logic [MARK_N-1:0] MARK_TEN = 8'b1011_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            startReq,
  input  logic            stopReq,
  input  logic            fieldRise,
  input  logic [HI_W-1:0] idHi,
  input  logic [LO_W-1:0] idLo,
  input  logic            elemLast,
  output tone_ctl_t       ctl,
  output logic            running
);
  localparam int HI_ID_W = ID_W - LO_W;
  localparam int BW = $clog2(ID_W);
  localparam int MW = $clog2(MARK_N);
  localparam int NW = $clog2(NIB_W);

  phase_e          phase;
  logic [MW-1:0]   markIdx;
  logic [BW-1:0]   bitIdx;
  logic            half;
  logic [ID_W-1:0] idReg;
  logic idOk, adv, curBit, frameWrap;

  assign idOk      = (idHi[HI_W-1:HI_ID_W] == '0);
  assign curBit    = idReg[bitIdx];
  assign adv       = ctl.step && elemLast;
  assign frameWrap = adv && (phase == PH_BIT) && half && (bitIdx == '0);

  always_comb begin
    ctl.step   = fieldRise && running && !stopReq;
    ctl.clear  = !running || stopReq;
    ctl.single = (phase == PH_LEAD) || (phase == PH_NIB);
    case (phase)
      PH_MARK: ctl.toneTen = MARK_TEN[markIdx];
      PH_BIT:  ctl.toneTen = half ? !curBit : curBit;
      default: ctl.toneTen = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= PH_LEAD;
      markIdx <= '0;
      bitIdx  <= '0;
      half    <= 1'b0;
      idReg   <= '0;
    end else if (stopReq) begin
      running <= 1'b0;
    end else if (!running) begin
      if (startReq && idOk) begin
        running <= 1'b1;
        phase   <= PH_LEAD;
        markIdx <= '0;
        half    <= 1'b0;
        idReg   <= {idHi[HI_ID_W-1:0], idLo};
      end
    end else if (adv) begin
      case (phase)
        PH_LEAD: begin
          phase   <= PH_MARK;
          markIdx <= '0;
        end
        PH_MARK: begin
          if (markIdx == MW'(MARK_N - 1)) begin
            phase  <= PH_NIB;
            bitIdx <= BW'(ID_W - 1);
          end else begin
            markIdx <= markIdx + 1'b1;
          end
        end
        PH_NIB: begin
          phase <= PH_BIT;
          half  <= 1'b0;
        end
        default: begin
          if (!half) begin
            half <= 1'b1;
          end else begin
            half <= 1'b0;
            if (bitIdx == '0) begin
              phase <= PH_LEAD;
              idReg <= {idHi[HI_ID_W-1:0], idLo};
            end else begin
              bitIdx <= bitIdx - 1'b1;
              if (bitIdx[NW-1:0] == '0) phase <= PH_NIB;
            end
          end
        end
      endcase
    end
  end

  // R11: an out-of-range upper word never starts the block
  p_refuse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && startReq && !idOk) |=> !running);

  // R6: bit index stays inside the ID
  p_bit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> bitIdx < BW'(ID_W));

  // R9: captured ID moves only at a frame wrap while running
  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !frameWrap) |=> $stable(idReg));

endmodule

// File: rtl/fsk_tag_emu.sv
module fsk_tag_emu
  import fsk_emu_pkg::*;
#(
  parameter int ID_W        = 44,
  parameter int HI_W        = 32,
  parameter int LO_W        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fieldClk,
  input  logic            startReq,
  input  logic            stopReq,
  input  logic [HI_W-1:0] idHi,
  input  logic [LO_W-1:0] idLo,
  output logic            coilOpen
);
  logic [SYNC_STAGES-1:0] syncReg;
  logic fieldPrev, fieldRise, elemLast, running;
  tone_ctl_t ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) syncReg[0] <= 1'b0;
    else        syncReg[0] <= fieldClk;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) syncReg[g] <= 1'b0;
      else        syncReg[g] <= syncReg[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fieldPrev <= 1'b0;
    else        fieldPrev <= syncReg[SYNC_STAGES-1];
  end

  assign fieldRise = syncReg[SYNC_STAGES-1] && !fieldPrev;

  fsk_frame_seq #(.ID_W(ID_W), .HI_W(HI_W), .LO_W(LO_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .stopReq(stopReq),
    .fieldRise(fieldRise), .idHi(idHi), .idLo(idLo), .elemLast(elemLast),
    .ctl(ctl), .running(running)
  );

  fsk_tone_gen u_tone (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .coilOpen(coilOpen), .elemLast(elemLast)
  );

  // R2: without a field edge or stop, the coil holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fieldRise && !stopReq) |=> $stable(coilOpen));

  // R10: stop shorts the coil on the next clock
  p_stop_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stopReq |=> !coilOpen && !running);

  // R1: idle means shorted coil
  p_idle_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !coilOpen);

endmodule

// File: tb/test_fsk_tag_emu.sv
module test_fsk_tag_emu;
  localparam int FRAME_LEN = 4800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fieldClk = 1'b0;
  logic startReq = 1'b0;
  logic stopReq = 1'b0;
  logic [31:0] idHi = '0;
  logic [31:0] idLo = '0;
  logic coilOpen;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fsk_tag_emu i_fsk_tag_emu (
    .clk(clk), .rst_n(rst_n), .fieldClk(fieldClk), .startReq(startReq),
    .stopReq(stopReq), .idHi(idHi), .idLo(idLo), .coilOpen(coilOpen)
  );

  function automatic bit toneAt(bit ten, int off);
    int len = ten ? 10 : 8;
    int high = ten ? 3 : 2;
    return (off % len) < high;
  endfunction

  // Expected coil value at frame position pos, built from R3..R7
  function automatic bit expBit(logic [43:0] id, int pos);
    int p = pos;
    if (p < 8) return p < 2;
    p -= 8;
    for (int m = 0; m < 8; m++) begin
      bit ten = (m >= 3 && m <= 5) || (m == 7);
      int len = ten ? 50 : 48;
      if (p < len) return toneAt(ten, p);
      p -= len;
    end
    for (int b = 43; b >= 0; b--) begin
      bit first = id[b];
      if (b % 4 == 3) begin
        if (p < 8) return p < 2;
        p -= 8;
      end
      if (p < (first ? 50 : 48)) return toneAt(first, p);
      p -= first ? 50 : 48;
      if (p < (first ? 48 : 50)) return toneAt(!first, p);
      p -= first ? 48 : 50;
    end
    return 1'b0;
  endfunction

  function automatic string regionTag(int pos);
    if (pos < 400) return "R5";
    if ((pos - 400) % 400 < 8) return "R7";
    return "R4";
  endfunction

  task automatic check(string tag, bit actual, bit expected, int pos);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s pos %0d actual %0b expected %0b", tag, pos, actual, expected);
    end
  endtask

  task automatic fieldPulse();
    @(negedge clk) fieldClk = 1'b1;
    repeat (4) @(negedge clk);
    fieldClk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // R3 R4 R5 R6 R7 R8 checked sample by sample against the frame model
  task automatic runSamples(logic [43:0] id, int startPos, int count, string forceTag);
    for (int i = 0; i < count; i++) begin
      int abs = startPos + i;
      int pos = abs % FRAME_LEN;
      string tag = forceTag != "" ? forceTag : (abs >= FRAME_LEN ? "R8" : regionTag(pos));
      fieldPulse();
      check(tag, coilOpen, expBit(id, pos), pos);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [43:0] idA, idB, idC;
    bit held;
    bit stayed;
    void'($urandom(32'h0005eed1));

    repeat (4) @(negedge clk);
    check("R1", coilOpen, 1'b0, -1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", coilOpen, 1'b0, -1);
    for (int i = 0; i < 5; i++) begin
      fieldPulse();
      check("R1", coilOpen, 1'b0, -1);
    end

    // Directed ID, full frame plus wrap
    idHi = 32'h0000_0A53;
    idLo = 32'h3C96_0F1E;
    idA = {idHi[11:0], idLo};
    pulseStart();
    runSamples(idA, 0, FRAME_LEN + 120, "");

    // R2: no field edge, coil holds
    held = coilOpen;
    repeat (60) @(negedge clk);
    check("R2", coilOpen, held, -1);

    // R9: change ID in mid-frame; old ID until wrap, new ID after
    idHi = $urandom() & 32'h0000_0FFF;
    idLo = $urandom();
    idB = {idHi[11:0], idLo};
    runSamples(idA, 120, FRAME_LEN - 120, "R9");
    runSamples(idB, 0, 600, "R9");

    // R10: stop in mid-frame
    @(negedge clk) stopReq = 1'b1;
    @(negedge clk) stopReq = 1'b0;
    @(negedge clk);
    check("R10", coilOpen, 1'b0, -1);
    stayed = 1'b1;
    for (int i = 0; i < 40; i++) begin
      fieldPulse();
      if (coilOpen !== 1'b0) stayed = 1'b0;
    end
    check("R10", stayed, 1'b1, -1);

    // R11: out-of-range upper word is refused
    idHi = 32'h0000_1000 | ($urandom() & 32'h0000_0FFF);
    pulseStart();
    stayed = 1'b1;
    for (int i = 0; i < 100; i++) begin
      fieldPulse();
      if (coilOpen !== 1'b0) stayed = 1'b0;
    end
    check("R11", stayed, 1'b1, -1);

    // Fresh start with a random valid ID, all-ones corner after
    idHi = $urandom() & 32'h0000_0FFF;
    idLo = $urandom();
    idC = {idHi[11:0], idLo};
    pulseStart();
    runSamples(idC, 0, 700, "");
    @(negedge clk) stopReq = 1'b1;
    @(negedge clk) stopReq = 1'b0;
    idHi = 32'h0000_0FFF;
    idLo = 32'hFFFF_FFFF;
    pulseStart();
    runSamples(44'hFFF_FFFF_FFFF, 0, 900, "R6");

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule